// File: doc/BRIEF.md
# Dual-Button Long-Press Reset Controller

This block produces a timed, active-low hard-reset pulse from two active-low push-buttons. A brief tap on either button, or on both, leaves the system running so that software can treat it as an interrupt. Only when both buttons are held down together, without a break, for a selectable multi-second setup time does the block drive its reset output low. It then holds the output low for a fixed reset timeout.

The same output also stretches supply failures. While the supply-good flag is low the output is held low. Once the flag returns high, the output stays low for one further reset timeout. The same stretch is applied after the block's own reset is released, which gives power-on reset behaviour.

All timing is counted in periods of an external tick enable, nominally one millisecond. The setup times and the timeout values are parameters, stated in ticks. The button inputs are synchronised inside the block. Threshold comparison, pull-ups and the open-drain driver sit outside it.

Top module: `dual_press_reset`

## Requirements
- R1: The reset output falls on the clock edge of the tick that completes the setup count. That count is a run of setup-time ticks during which both synchronised buttons read low together and without a break. No other button pattern can drive the output low.
- R2: The setup time follows setup_sel_i: 2'b00 selects SETUP_SHORT_TICKS (default 2000), 2'b01 selects SETUP_MID_TICKS (default 6000), and 2'b10 or 2'b11 select SETUP_LONG_TICKS (default 10000).
- R3: If either button is released before the setup count completes, the hold count clears to zero. A joint press shorter than the setup time is therefore ignored, and a single held button never fires.
- R4: After a button-triggered fire, the reset output stays low for exactly the timeout number of ticks. It can return high only on a clock edge where tick_i is high.
- R5: The timeout follows tmo_sel_i: 0 selects TMO_SHORT_TICKS (default 140), and 1 selects TMO_LONG_TICKS (default 240).
- R6: While supply_ok_i is low, the reset output is low from the next clock edge. After supply_ok_i returns high, the output stays low for exactly the timeout number of ticks.
- R7: While rst_ni is low the reset output is low. After rst_ni is released, the output stays low for exactly the timeout number of ticks.
- R8: After a button-triggered fire, no further fire occurs until both buttons have been seen released (high) at the same time and then pressed together again.
- R9: Each button passes through a two-flop synchroniser that resets to the released level. The hold count and the timeout count advance only on cycles where tick_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base enable, one cycle per tick |
| btn_a_ni | input | 1 | First push-button, active low, asynchronous |
| btn_b_ni | input | 1 | Second push-button, active low, asynchronous |
| setup_sel_i | input | 2 | Setup-time select (see R2) |
| supply_ok_i | input | 1 | Supply-good flag, low means undervoltage |
| tmo_sel_i | input | 1 | Reset timeout strap (see R5) |
| sys_rst_no | output | 1 | Reset output, active low |

## Verification
The assertions check four rules on every cycle:
- An undervoltage cycle is always followed by a low output.
- A low output cannot be released without a tick.
- The hold count is zero whenever the buttons are not both low.
- Any fall of the output that is not caused by the supply was preceded by a joint press, and every fire disarms the trigger.

Some behaviour can only be shown by the bench scenarios:
- the exact number of ticks from a press to the fall for each setup selection, and the exact pulse length for each timeout strap;
- that a press one tick too short, a single held button, and a press held past the pulse all produce no pulse.

// File: rtl/dual_press_reset_pkg.sv
package dual_press_reset_pkg;
  typedef enum logic [1:0] {
    SEL_SHORT = 2'b00,
    SEL_MID   = 2'b01,
    SEL_LONG  = 2'b10,
    SEL_LONG2 = 2'b11
  } setup_sel_e;
endpackage

// File: rtl/dpr_sync.sv
module dpr_sync #(
  parameter int unsigned W       = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL;
        sync_q <= RST_VAL;
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end
    assign q_o[i] = sync_q;
  end
endmodule

// File: rtl/dpr_hold.sv
module dpr_hold #(
  parameter int unsigned SW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [1:0]    btn_n_i,
  input  logic [SW-1:0] limit_i,
  output logic          fire_o,
  output logic          both_low_o,
  output logic          armed_o,
  output logic [SW-1:0] cnt_o
);
  logic          both_low, both_high, at_limit;
  logic [SW-1:0] cnt_q;
  logic          armed_q;

  assign both_low  = (btn_n_i == 2'b00);
  assign both_high = (btn_n_i == 2'b11);
  assign at_limit  = (cnt_q >= limit_i - SW'(1));
  assign fire_o    = both_low && armed_q && tick_i && at_limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!both_low || fire_o) begin
      cnt_q <= '0;
    end else if (armed_q && tick_i) begin
      cnt_q <= cnt_q + SW'(1);
    end
  end

  // re-arm only once both buttons are seen released
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b1;
    else if (fire_o)    armed_q <= 1'b0;
    else if (both_high) armed_q <= 1'b1;
  end

  assign both_low_o = both_low;
  assign armed_o    = armed_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/dpr_stretch.sv
module dpr_stretch #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          fire_i,
  input  logic          supply_ok_i,
  input  logic [TW-1:0] limit_i,
  output logic          active_o
);
  logic          active_q;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (!supply_ok_i || fire_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && tick_i) begin
      if (cnt_q >= limit_i - TW'(1)) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + TW'(1);
      end
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/dual_press_reset.sv
module dual_press_reset
  import dual_press_reset_pkg::*;
#(
  parameter int unsigned SETUP_SHORT_TICKS = 2000,
  parameter int unsigned SETUP_MID_TICKS   = 6000,
  parameter int unsigned SETUP_LONG_TICKS  = 10000,
  parameter int unsigned TMO_SHORT_TICKS   = 140,
  parameter int unsigned TMO_LONG_TICKS    = 240
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       btn_a_ni,
  input  logic       btn_b_ni,
  input  logic [1:0] setup_sel_i,
  input  logic       supply_ok_i,
  input  logic       tmo_sel_i,
  output logic       sys_rst_no
);
  localparam int unsigned SW = $clog2(SETUP_LONG_TICKS + 1);
  localparam int unsigned TW = $clog2(TMO_LONG_TICKS + 1);
  localparam logic [SW-1:0] LIM_SHORT = SW'(SETUP_SHORT_TICKS);
  localparam logic [SW-1:0] LIM_MID   = SW'(SETUP_MID_TICKS);
  localparam logic [SW-1:0] LIM_LONG  = SW'(SETUP_LONG_TICKS);
  localparam logic [TW-1:0] TMO_A     = TW'(TMO_SHORT_TICKS);
  localparam logic [TW-1:0] TMO_B     = TW'(TMO_LONG_TICKS);

  logic [1:0]    btn_s;
  logic [SW-1:0] setup_lim;
  logic [TW-1:0] tmo_lim;
  logic          fire, both_low, armed, active;
  logic [SW-1:0] hold_cnt;

  dpr_sync #(.W(2), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({btn_b_ni, btn_a_ni}),
    .q_o   (btn_s)
  );

  always_comb begin
    unique case (setup_sel_e'(setup_sel_i))
      SEL_SHORT: setup_lim = LIM_SHORT;
      SEL_MID:   setup_lim = LIM_MID;
      default:   setup_lim = LIM_LONG;
    endcase
  end

  assign tmo_lim = tmo_sel_i ? TMO_B : TMO_A;

  dpr_hold #(.SW(SW)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .btn_n_i   (btn_s),
    .limit_i   (setup_lim),
    .fire_o    (fire),
    .both_low_o(both_low),
    .armed_o   (armed),
    .cnt_o     (hold_cnt)
  );

  dpr_stretch #(.TW(TW)) u_stretch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .fire_i     (fire),
    .supply_ok_i(supply_ok_i),
    .limit_i    (tmo_lim),
    .active_o   (active)
  );

  assign sys_rst_no = ~active;
endmodule

// File: rtl/dual_press_reset_chk.sv
module dual_press_reset_chk #(
  parameter int unsigned SW = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          supply_ok_i,
  input logic          sys_rst_no,
  input logic          fire_i,
  input logic          both_low_i,
  input logic          armed_i,
  input logic [SW-1:0] hold_cnt_i
);
  // R6
  supply_low_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !sys_rst_no);

  // R4
  release_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_no && !tick_i) |=> !sys_rst_no);

  // R3
  hold_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !both_low_i |=> (hold_cnt_i == '0));

  // R1
  fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_no) |-> (!$past(supply_ok_i) || $past(both_low_i)));

  // R8
  disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> !armed_i);
endmodule

bind dual_press_reset dual_press_reset_chk #(.SW(SW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .supply_ok_i(supply_ok_i),
  .sys_rst_no (sys_rst_no),
  .fire_i     (fire),
  .both_low_i (both_low),
  .armed_i    (armed),
  .hold_cnt_i (hold_cnt)
);

// File: tb/dual_press_reset_test.sv
`timescale 1ns/1ps
module dual_press_reset_test;
  localparam int S_SHORT = 3, S_MID = 5, S_LONG = 8;
  localparam int T_A = 4, T_B = 6, TDIV = 4;

  logic clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic btn_a = 1'b1, btn_b = 1'b1, supply_ok = 1'b1, tmo_sel = 1'b0;
  logic [1:0] sel = 2'b00;
  logic sys_rst_no;

  int runs = 0, fails = 0, tick_n = 0, len = 0, div = 0, cycles = 0;
  logic last_rst = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  dual_press_reset #(
    .SETUP_SHORT_TICKS(S_SHORT), .SETUP_MID_TICKS(S_MID), .SETUP_LONG_TICKS(S_LONG),
    .TMO_SHORT_TICKS(T_A), .TMO_LONG_TICKS(T_B)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .btn_a_ni(btn_a), .btn_b_ni(btn_b),
    .setup_sel_i(sel), .supply_ok_i(supply_ok), .tmo_sel_i(tmo_sel), .sys_rst_no(sys_rst_no)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  endtask

  // monitor + tick source: pulse lengths in ticks, compared against the scoreboard
  always @(negedge clk) begin
    cycles++;
    if (tick_i) tick_n++;
    if (rst_ni && tick_i && !last_rst && supply_ok) len++;
    if (rst_ni && !last_rst && sys_rst_no) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected pulse", len, 0);
      end else begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(len == e, t, len, e);
      end
    end
    if (last_rst && !sys_rst_no) len = 0;
    last_rst = sys_rst_no;
    div = (div == TDIV - 1) ? 0 : div + 1;
    tick_i = (div == TDIV - 1);
    if (cycles > 150000) begin
      check(1'b0, "watchdog", cycles, 150000);
      summary();
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_ticks(input int n);
    automatic int t0 = tick_n;
    while (tick_n - t0 < n) step();
  endtask

  task automatic align_tick();
    automatic int t0 = tick_n;
    while (tick_n == t0) step();
  endtask

  task automatic wait_high();
    automatic int k = 0;
    while (!sys_rst_no && k < 2000) begin step(); k++; end
  endtask

  task automatic expect_pulse(input int n, input string tag);
    exp_q.push_back(n);
    tag_q.push_back(tag);
  endtask

  // joint press held until fall; checks the tick count from press to fall
  task automatic press_fire(input int s, input int t, input string tag);
    automatic int t0, k = 0;
    expect_pulse(t, {tag, " pulse length"});
    align_tick();
    btn_a = 1'b0; btn_b = 1'b0;
    t0 = tick_n;
    while (sys_rst_no && k < 2000) begin step(); k++; end
    check(tick_n - t0 == s, {tag, " setup ticks"}, tick_n - t0, s);
    wait_high();
  endtask

  task automatic release_all();
    btn_a = 1'b1; btn_b = 1'b1;
    wait_ticks(2);
  endtask

  task automatic stays_high(input int n, input string tag);
    automatic bit low_seen = 1'b0;
    automatic int t0 = tick_n;
    while (tick_n - t0 < n) begin
      if (!sys_rst_no) low_seen = 1'b1;
      step();
    end
    check(!low_seen, tag, 0, 1);
  endtask

  initial begin
    repeat (5) step();
    check(sys_rst_no == 1'b0, "R7 low during reset", sys_rst_no, 0);
    expect_pulse(T_A, "R7 power-up stretch");
    rst_ni = 1'b1;
    step();
    check(sys_rst_no == 1'b0, "R7 low after release", sys_rst_no, 0);
    wait_high();
    check(exp_q.size() == 0, "R7 power-up pulse seen", exp_q.size(), 0);

    // R1 R2 sel 00, R4 R5 tmo A
    sel = 2'b00;
    press_fire(S_SHORT, T_A, "R1 R2 sel00");
    // R8 buttons still held: no second pulse
    stays_high(3 * S_LONG, "R8 held past pulse no refire");
    release_all();

    sel = 2'b01; tmo_sel = 1'b1;
    press_fire(S_MID, T_B, "R2 R5 sel01 tmoB");
    release_all();

    sel = 2'b10; tmo_sel = 1'b0;
    press_fire(S_LONG, T_A, "R2 sel10");
    release_all();

    sel = 2'b11; tmo_sel = 1'b1;
    press_fire(S_LONG, T_B, "R2 R4 sel11");
    release_all();

    // R3 short presses, count clears between them
    sel = 2'b01; tmo_sel = 1'b0;
    for (int i = 0; i < 2; i++) begin
      automatic int t0;
      align_tick();
      btn_a = 1'b0; btn_b = 1'b0;
      t0 = tick_n;
      while (tick_n - t0 < S_MID - 1) step();
      release_all();
    end
    stays_high(S_LONG, "R3 short presses ignored");

    // R3 single button held long
    btn_a = 1'b0;
    stays_high(3 * S_LONG, "R3 single button ignored");
    btn_a = 1'b1;
    btn_b = 1'b0;
    stays_high(3 * S_LONG, "R3 other button ignored");
    release_all();

    // R9 inputs pass a two-flop synchroniser
    sel = 2'b00;
    expect_pulse(T_A, "R9 pulse length");
    align_tick();
    btn_a = 1'b0; btn_b = 1'b0;
    step();
    check(sys_rst_no == 1'b1, "R9 no early fall", sys_rst_no, 1);
    wait_ticks(S_SHORT);
    step();
    check(sys_rst_no == 1'b0, "R9 fall after setup", sys_rst_no, 0);
    wait_high();
    release_all();

    // R6 supply fail
    tmo_sel = 1'b1;
    expect_pulse(T_B, "R6 supply stretch");
    supply_ok = 1'b0;
    step();
    check(sys_rst_no == 1'b0, "R6 low on undervoltage", sys_rst_no, 0);
    wait_ticks(5);
    check(sys_rst_no == 1'b0, "R6 held during undervoltage", sys_rst_no, 0);
    supply_ok = 1'b1;
    wait_high();

    wait_ticks(4);
    check(exp_q.size() == 0, "R4 all pulses matched", exp_q.size(), 0);
    summary();
  end
endmodule